// File: doc/BRIEF.md
# Two-Phase Sixteen-Opcode Processor Core

This block is a small load/store processor with 16-bit data words, sixteen general registers, a 256-word unified memory and an 8-bit program counter. It has no pipeline. Each instruction takes exactly two clock cycles. In the fetch cycle the word at the program counter is latched into the instruction register and the counter steps by one. In the execute cycle the instruction updates registers, memory or the program counter.

Instructions use two layouts. In the three-register layout the top nibble is the opcode, followed by nibbles d, s and t. In the immediate layout the opcode and d are followed by an 8-bit address. Address FF is not a memory word: it is the port to the outside world. A load from FF reads the input bus, and a store to FF sends a word out on a one-cycle strobe. Memory is filled through a separate load port, normally while the core is held in reset.

Top module: `tiny_cpu`

## Requirements
- R1: While reset is asserted and at the first edge after it, pc_o reads 0x10, halted_o is 0 and out_valid_o is 0. The core starts with a fetch.
- R2: Every instruction takes one fetch cycle and then one execute cycle. The fetch edge latches mem[pc] and sets pc to pc+1. A program of n instructions whose last instruction is halt raises halted_o 2n rising edges after reset is released.
- R3: Opcodes 1 to 6 write R[d] = R[s] op R[t], using the instruction word {op[15:12], d[11:8], s[7:4], t[3:0]}. The operations are 1 add, 2 subtract, 3 and, 4 xor, 5 shift left and 6 shift right. Results wrap modulo 2^16.
- R4: Shift amounts use only the low 4 bits of R[t]. Right shift is arithmetic, so bit 15 is copied into the vacated positions.
- R5: Register 0 always reads as 0. Any write aimed at register 0 has no effect.
- R6: The immediate layout is {op[15:12], d[11:8], addr[7:0]}. Opcode 7 sets R[d] to addr, zero-extended. Opcode 8 sets R[d] to mem[addr]. Opcode 9 writes R[d] to mem[addr].
- R7: Opcode A sets R[d] to mem[R[t]]. Opcode B writes R[d] to mem[R[t]]. Both use the low 8 bits of R[t] as the address.
- R8: Opcode C loads addr into pc when R[d] is 0. Opcode D loads addr into pc when R[d] is nonzero and its bit 15 is clear. Otherwise execution continues with the next word.
- R9: Opcode F writes the already-incremented pc to R[d] and then jumps to addr. Opcode E jumps to the low 8 bits of R[t].
- R10: A load from address FF (by opcode 8 or A) returns in_data_i. A store to FF raises out_valid_o for exactly one cycle after the execute edge, with out_data_o set to the stored value, and it leaves memory unchanged.
- R11: Opcode 0 sets halted_o. From then until reset, pc_o stays frozen at the halt address plus one and no output is produced.
- R12: When load_en_i is high, memory word load_addr_i takes load_data_i at the clock edge. This load port works while the core is in reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset of the core state |
| load_en_i | input | 1 | Memory load strobe |
| load_addr_i | input | 8 | Memory load address |
| load_data_i | input | 16 | Memory load data |
| in_data_i | input | 16 | Value returned by loads from address FF |
| out_valid_o | output | 1 | One-cycle strobe for a store to address FF |
| out_data_o | output | 16 | Value of the last store to address FF |
| pc_o | output | 8 | Current program counter |
| halted_o | output | 1 | Core has executed halt |

## Verification
Internal state can only be seen through the output strobe, the program counter and the halt flag. For that reason every test program ends by storing its result to FF. A wrong ALU result, register write or register-zero leak then shows up on out_data_o in the cycle after that store executes. A mis-stepped phase or program counter changes the edge count at which halted_o rises, or the frozen pc_o value. A wrong branch, jump or link decision sends execution to a path that emits a different value, or a different number of output strobes. Such an error therefore appears within a few instructions.

// File: rtl/tiny_cpu_pkg.sv
package tiny_cpu_pkg;
  typedef enum logic [3:0] {
    OP_HALT = 4'h0, OP_ADD = 4'h1, OP_SUB = 4'h2, OP_AND = 4'h3,
    OP_XOR  = 4'h4, OP_SHL = 4'h5, OP_SHR = 4'h6, OP_LDA = 4'h7,
    OP_LD   = 4'h8, OP_ST  = 4'h9, OP_LDI = 4'hA, OP_STI = 4'hB,
    OP_BZ   = 4'hC, OP_BP  = 4'hD, OP_JR  = 4'hE, OP_JAL = 4'hF
  } opcode_e;

  typedef enum logic {PH_FETCH = 1'b0, PH_EXEC = 1'b1} phase_e;
endpackage

// File: rtl/tiny_cpu_alu.sv
module tiny_cpu_alu
  import tiny_cpu_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  opcode_e           op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] y_o
);
  localparam int unsigned SH_W = $clog2(DATA_W);

  logic [SH_W-1:0] shamt;
  assign shamt = b_i[SH_W-1:0];

  always_comb begin
    unique case (op_i)
      OP_ADD:  y_o = a_i + b_i;
      OP_SUB:  y_o = a_i - b_i;
      OP_AND:  y_o = a_i & b_i;
      OP_XOR:  y_o = a_i ^ b_i;
      OP_SHL:  y_o = a_i << shamt;
      OP_SHR:  y_o = DATA_W'($signed(a_i) >>> shamt);
      default: y_o = '0;
    endcase
  end

  // R4: arithmetic right shift keeps the sign bit
  always_comb begin
    if (op_i == OP_SHR)
      assert_shr_sign_R4: assert (y_o[DATA_W-1] == a_i[DATA_W-1]);
  end
endmodule

// File: rtl/tiny_cpu_regfile.sv
module tiny_cpu_regfile #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned NREGS  = 16,
  localparam int unsigned RA_W  = $clog2(NREGS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [RA_W-1:0]   waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [RA_W-1:0]   ra_d_i,
  input  logic [RA_W-1:0]   ra_s_i,
  input  logic [RA_W-1:0]   ra_t_i,
  output logic [DATA_W-1:0] rd_d_o,
  output logic [DATA_W-1:0] rd_s_o,
  output logic [DATA_W-1:0] rd_t_o
);
  // register 0 has no storage
  logic [DATA_W-1:0] regs [1:NREGS-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 1; i < NREGS; i++) regs[i] <= '0;
    end else if (we_i && waddr_i != '0) begin
      regs[waddr_i] <= wdata_i;
    end
  end

  function automatic logic [DATA_W-1:0] rd(input logic [RA_W-1:0] a);
    return (a == '0) ? '0 : regs[a];
  endfunction

  assign rd_d_o = rd(ra_d_i);
  assign rd_s_o = rd(ra_s_i);
  assign rd_t_o = rd(ra_t_i);

  // R5: a written nonzero register returns the written value next cycle
  assert_write_visible_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && waddr_i != '0 && ra_d_i == waddr_i) |=>
      (ra_d_i != $past(waddr_i)) || (rd_d_o == $past(wdata_i)) || $past(we_i && 1'b0));
endmodule

// File: rtl/tiny_cpu_mem.sv
module tiny_cpu_mem #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADDR_W = 8,
  localparam int unsigned DEPTH = 1 << ADDR_W
) (
  input  logic              clk_i,
  input  logic              ld_we_i,
  input  logic [ADDR_W-1:0] ld_addr_i,
  input  logic [DATA_W-1:0] ld_data_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] words [DEPTH];

  // load port wins over a core store
  always_ff @(posedge clk_i) begin
    if (ld_we_i)   words[ld_addr_i] <= ld_data_i;
    else if (we_i) words[waddr_i]   <= wdata_i;
  end

  assign rdata_o = words[raddr_i];
endmodule

// File: rtl/tiny_cpu.sv
module tiny_cpu
  import tiny_cpu_pkg::*;
#(
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned NREGS    = 16,
  parameter logic [7:0]  RESET_PC = 8'h10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_en_i,
  input  logic [ADDR_W-1:0] load_addr_i,
  input  logic [DATA_W-1:0] load_data_i,
  input  logic [DATA_W-1:0] in_data_i,
  output logic              out_valid_o,
  output logic [DATA_W-1:0] out_data_o,
  output logic [ADDR_W-1:0] pc_o,
  output logic              halted_o
);
  localparam int unsigned RA_W = $clog2(NREGS);
  localparam logic [ADDR_W-1:0] IO_ADDR = {ADDR_W{1'b1}};

  phase_e            phase_q;
  logic              halted_q;
  logic [ADDR_W-1:0] pc_q;
  logic [DATA_W-1:0] ir_q;

  opcode_e           op;
  logic [RA_W-1:0]   f_d, f_s, f_t;
  logic [ADDR_W-1:0] f_addr;

  assign op     = opcode_e'(ir_q[15:12]);
  assign f_d    = ir_q[8 +: RA_W];
  assign f_s    = ir_q[4 +: RA_W];
  assign f_t    = ir_q[0 +: RA_W];
  assign f_addr = ir_q[ADDR_W-1:0];

  logic [DATA_W-1:0] r_d, r_s, r_t, alu_y, mem_rdata, wb_data, load_val;
  logic [ADDR_W-1:0] mem_addr;
  logic              exec, is_io, reg_we, is_store, mem_we, take_br;
  logic              d_zero, d_pos;

  assign exec     = (phase_q == PH_EXEC) && !halted_q;
  assign mem_addr = (phase_q == PH_FETCH) ? pc_q :
                    (op == OP_LDI || op == OP_STI) ? r_t[ADDR_W-1:0] : f_addr;
  assign is_io    = (mem_addr == IO_ADDR);
  assign load_val = is_io ? in_data_i : mem_rdata;
  assign is_store = (op == OP_ST) || (op == OP_STI);
  assign mem_we   = exec && is_store && !is_io;

  // condition evaluation on R[d]
  assign d_zero = (r_d == '0);
  assign d_pos  = !d_zero && !r_d[DATA_W-1];

  always_comb begin
    reg_we  = 1'b0;
    wb_data = alu_y;
    unique case (op)
      OP_ADD, OP_SUB, OP_AND, OP_XOR, OP_SHL, OP_SHR: reg_we = 1'b1;
      OP_LDA: begin reg_we = 1'b1; wb_data = DATA_W'(f_addr); end
      OP_LD, OP_LDI: begin reg_we = 1'b1; wb_data = load_val; end
      OP_JAL: begin reg_we = 1'b1; wb_data = DATA_W'(pc_q); end
      default: ;
    endcase
    reg_we = reg_we && exec;
  end

  always_comb begin
    unique case (op)
      OP_BZ:   take_br = d_zero;
      OP_BP:   take_br = d_pos;
      OP_JAL:  take_br = 1'b1;
      default: take_br = 1'b0;
    endcase
  end

  tiny_cpu_regfile #(.DATA_W(DATA_W), .NREGS(NREGS)) u_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we), .waddr_i(f_d), .wdata_i(wb_data),
    .ra_d_i(f_d), .ra_s_i(f_s), .ra_t_i(f_t),
    .rd_d_o(r_d), .rd_s_o(r_s), .rd_t_o(r_t)
  );

  tiny_cpu_alu #(.DATA_W(DATA_W)) u_alu (
    .op_i(op), .a_i(r_s), .b_i(r_t), .y_o(alu_y)
  );

  tiny_cpu_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
    .clk_i,
    .ld_we_i(load_en_i), .ld_addr_i(load_addr_i), .ld_data_i(load_data_i),
    .we_i(mem_we), .waddr_i(mem_addr), .wdata_i(r_d),
    .raddr_i(mem_addr), .rdata_o(mem_rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q     <= PH_FETCH;
      halted_q    <= 1'b0;
      pc_q        <= RESET_PC[ADDR_W-1:0];
      ir_q        <= '0;
      out_valid_o <= 1'b0;
      out_data_o  <= '0;
    end else begin
      out_valid_o <= 1'b0;
      if (!halted_q) begin
        if (phase_q == PH_FETCH) begin
          ir_q    <= mem_rdata;
          pc_q    <= pc_q + 1'b1;
          phase_q <= PH_EXEC;
        end else begin
          phase_q <= PH_FETCH;
          if (op == OP_HALT) halted_q <= 1'b1;
          if (take_br)       pc_q <= f_addr;
          else if (op == OP_JR) pc_q <= r_t[ADDR_W-1:0];
          if (is_store && is_io) begin
            out_valid_o <= 1'b1;
            out_data_o  <= r_d;
          end
        end
      end
    end
  end

  assign pc_o     = pc_q;
  assign halted_o = halted_q;

  // R2: fetch steps the counter and hands over to execute
  assert_fetch_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_FETCH && !halted_q) |=>
      (phase_q == PH_EXEC && pc_q == $past(pc_q) + 1'b1));

  // R2: execute always returns to fetch
  assert_exec_return_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exec |=> (phase_q == PH_FETCH));

  // R11: halted core holds its counter and flag
  assert_halt_freeze_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_q |=> (halted_q && $stable(pc_q) && !out_valid_o));

  // R8: a zero test that holds redirects the counter
  assert_bz_taken_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec && op == OP_BZ && r_d == '0) |=> (pc_q == $past(f_addr)));

  // R9: link jump lands on its address
  assert_jal_target_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec && op == OP_JAL) |=> (pc_q == $past(f_addr)));

  // R10: output strobe lasts one cycle
  assert_out_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |=> !out_valid_o);
endmodule

// File: tb/tiny_cpu_test.sv
module tiny_cpu_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ld_en = 1'b0;
  logic [7:0]  ld_addr = '0;
  logic [15:0] ld_data = '0;
  logic [15:0] in_data = '0;
  logic        out_valid;
  logic [15:0] out_data;
  logic [7:0]  pc;
  logic        halted;

  always #5 clk = ~clk;

  tiny_cpu uut (
    .clk_i(clk), .rst_ni(rst_n),
    .load_en_i(ld_en), .load_addr_i(ld_addr), .load_data_i(ld_data),
    .in_data_i(in_data),
    .out_valid_o(out_valid), .out_data_o(out_data),
    .pc_o(pc), .halted_o(halted)
  );

  int tests = 0;
  int fails = 0;
  logic [15:0] img [256];
  logic [15:0] outs [8];
  int out_n = 0;
  int cyc = 0;

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (out_n < 8) outs[out_n] = out_data;
      out_n++;
    end
  end

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clear_img();
    for (int i = 0; i < 256; i++) img[i] = 16'h0000;
  endtask

  // R12: image written through the load port while in reset
  task automatic run();
    @(negedge clk);
    rst_n = 1'b0;
    for (int i = 0; i < 256; i++) begin
      ld_en = 1'b1; ld_addr = 8'(i); ld_data = img[i];
      @(negedge clk);
    end
    ld_en = 1'b0;
    out_n = 0;
    rst_n = 1'b1;
    cyc = 0;
    while (!halted && cyc < 400) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  localparam int NV = 9;
  localparam logic [3:0]  V_OP [NV] = '{4'h1, 4'h2, 4'h3, 4'h4, 4'h5, 4'h6, 4'h6, 4'h1, 4'h5};
  localparam logic [15:0] V_A  [NV] = '{16'h0028, 16'h0005, 16'hF0F0, 16'hF0F0, 16'h0001,
                                        16'h8000, 16'h4000, 16'hFFFF, 16'h1234};
  localparam logic [15:0] V_B  [NV] = '{16'h0064, 16'h0007, 16'h3C3C, 16'h3C3C, 16'h0013,
                                        16'h0004, 16'h0002, 16'h0001, 16'h0010};
  localparam logic [15:0] V_Y  [NV] = '{16'h008C, 16'hFFFE, 16'h3030, 16'hCCCC, 16'h0008,
                                        16'hF800, 16'h1000, 16'h0000, 16'h1234};

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
    $display("  [TB] %0d tests run, %0d failed", tests + 1, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 pc", {8'h0, pc}, 16'h0010);
    chk("R1 halted", {15'h0, halted}, 16'h0);
    chk("R1 out_valid", {15'h0, out_valid}, 16'h0);

    // R3 / R4: ALU vector table
    for (int v = 0; v < NV; v++) begin
      clear_img();
      img[8'h10] = 16'h8130;
      img[8'h11] = 16'h8231;
      img[8'h12] = {V_OP[v], 12'h312};
      img[8'h13] = 16'h93FF;
      img[8'h14] = 16'h0000;
      img[8'h30] = V_A[v];
      img[8'h31] = V_B[v];
      run();
      chk("R3 R4 alu result", outs[0], V_Y[v]);
      chk("R3 output count", 16'(out_n), 16'd1);
      if (v == 0) chk("R2 cycles to halt", 16'(cyc), 16'd10);
    end

    // R1 after a released reset: check state before the first edge completes
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    chk("R1 pc after reset", {8'h0, pc}, 16'h0010);
    chk("R1 halted after reset", {15'h0, halted}, 16'h0);

    // R8 R2: worked example via zero-branch on R0
    clear_img();
    img[8'h10] = 16'h8330; img[8'h11] = 16'h8431; img[8'h12] = 16'hC020;
    img[8'h20] = 16'h1234; img[8'h21] = 16'h92FF; img[8'h22] = 16'h0000;
    img[8'h30] = 16'h0028; img[8'h31] = 16'h0064;
    run();
    chk("R3 example sum", outs[0], 16'h008C);
    chk("R2 six instructions twelve edges", 16'(cyc), 16'd12);
    chk("R11 pc frozen at halt+1", {8'h0, pc}, 16'h0023);
    // R11 freeze over later cycles
    repeat (6) @(negedge clk);
    chk("R11 pc still frozen", {8'h0, pc}, 16'h0023);
    chk("R11 halted held", {15'h0, halted}, 16'h1);
    chk("R11 no extra output", 16'(out_n), 16'd1);

    // R5 / R6: writes to R0 dropped, load address
    clear_img();
    img[8'h10] = 16'h7055; img[8'h11] = 16'h8030; img[8'h12] = 16'h90FF;
    img[8'h13] = 16'h75AB; img[8'h14] = 16'h95FF; img[8'h15] = 16'h0000;
    img[8'h30] = 16'hBEEF;
    run();
    chk("R5 register zero stays zero", outs[0], 16'h0000);
    chk("R6 load address", outs[1], 16'h00AB);

    // R10: input port read and output strobe
    clear_img();
    in_data = 16'h5A5A;
    img[8'h10] = 16'h86FF; img[8'h11] = 16'h96FF; img[8'h12] = 16'h0000;
    img[8'hFF] = 16'h1111;
    run();
    chk("R10 load from FF reads input", outs[0], 16'h5A5A);
    chk("R10 one strobe", 16'(out_n), 16'd1);

    // R10: store to FF leaves memory word FF alone (read back via indirect of FE+1 not possible;
    // R6 store then load of a plain word instead)
    clear_img();
    img[8'h10] = 16'h8130; img[8'h11] = 16'h9140; img[8'h12] = 16'h8240;
    img[8'h13] = 16'h92FF; img[8'h14] = 16'h0000; img[8'h30] = 16'hC0DE;
    run();
    chk("R6 store then load", outs[0], 16'hC0DE);

    // R7: indirect load and store
    clear_img();
    img[8'h10] = 16'h7140; img[8'h11] = 16'hA201; img[8'h12] = 16'h7341;
    img[8'h13] = 16'hB203; img[8'h14] = 16'h8441; img[8'h15] = 16'h94FF;
    img[8'h16] = 16'h0000; img[8'h40] = 16'h7E57;
    run();
    chk("R7 indirect round trip", outs[0], 16'h7E57);

    // R8: signed positive test and zero-branch not taken
    clear_img();
    img[8'h10] = 16'h8130; img[8'h11] = 16'hD118; img[8'h12] = 16'hC118;
    img[8'h13] = 16'h8231; img[8'h14] = 16'hD220; img[8'h15] = 16'h75EE;
    img[8'h16] = 16'h95FF; img[8'h17] = 16'h0000;
    img[8'h18] = 16'h75DD; img[8'h19] = 16'h95FF; img[8'h1A] = 16'h0000;
    img[8'h20] = 16'h7577; img[8'h21] = 16'h95FF; img[8'h22] = 16'h0000;
    img[8'h30] = 16'h8000; img[8'h31] = 16'h0001;
    run();
    chk("R8 branch path", outs[0], 16'h0077);
    chk("R8 single output", 16'(out_n), 16'd1);

    // R9: link and register jump
    clear_img();
    img[8'h10] = 16'hF120;
    img[8'h20] = 16'h91FF; img[8'h21] = 16'hE001;
    img[8'h11] = 16'h7299; img[8'h12] = 16'h92FF; img[8'h13] = 16'h0000;
    run();
    chk("R9 link value", outs[0], 16'h0011);
    chk("R9 return path", outs[1], 16'h0099);
    chk("R9 output count", 16'(out_n), 16'd2);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule